// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a programmable countdown timer that sits beside a processor's interrupt controller and is driven through a small 32-bit register port. Software loads a start value, chooses a power-of-two divider for an external tick enable, and programs a control word that carries the interrupt vector, a mask flag and a one-shot/periodic flag. The counter steps down once per divided tick. When it runs out and the control word is unmasked, the block emits a one-cycle request pulse with the programmed vector beside it. The request is always edge-type. Routing it to a processor is left to surrounding logic.

The current count is visible as a read-only register. In one-shot mode it stops at zero and fires once. In periodic mode it wraps back to the start value, so each period is one tick longer than the start value. Rewriting the start value restarts both the count and the divider.

Top module: `local_irq_timer`

## Requirements
- R1: The divide register keeps only write-data bits 3, 1 and 0. They form the code {bit3, bit1, bit0}. The count steps once every 2^((code+1) mod 8) tick-enable pulses, so code 7 steps on every pulse. A read returns the kept bits in their places and zero elsewhere.
- R2: A write to the start-value register (word 0x38) loads the current count with that value and restarts the divider. The first decrement comes after a full divide ratio of tick-enable pulses counted from the write.
- R3: With control bit 17 clear (one-shot), the count falls by one per divided tick to zero and then stays at zero. On the divided tick after zero is reached, exactly one request is raised. A start value of zero raises no request.
- R4: With control bit 17 set (periodic), a divided tick at count zero reloads the start value. The count reads start − (elapsed mod (start+1)), and a request is raised at every reload, i.e. every start+1 divided ticks.
- R5: While control bit 16 (mask) is set, no request is raised. The count still advances as in R3 and R4.
- R6: A request is a one-cycle high pulse on `irq_pulse`. It appears in the cycle after the clock edge that consumes the expiring tick. `irq_vector` then shows control bits 7:0 and holds that value until the next request.
- R7: The word addresses are 0x32 for control, 0x38 for the start value, 0x39 for the current count and 0x3E for the divider. Writes to 0x39 change no register. Reads of any other address return zero.
- R8: After reset the control word reads 0x00010000 (masked, one-shot, vector 0). The start value, divider, current count and `irq_vector` read zero, and `irq_pulse` is low.
- R9: A write to the control word re-evaluates expiry with its new mask and mode bits. If a one-shot count is unmasked while the count is still above zero, the request fires when that count expires. If it is unmasked after the count has reached zero, no request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Undivided timer tick enable, one pulse per tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address (byte address >> 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the latest request |

## Verification
The in-line properties check on every cycle that:
- a request only follows a divided tick taken at count zero;
- an expired one-shot count stays at zero;
- a periodic count reloads the start value;
- an armed expiry never coexists with the mask;
- the vector is held between requests;
- a current-count write leaves all registers unchanged;
- a start-value write clears the divider.

Only the bench scenarios can show the exact divide ratio for each of the eight codes and the read-back of the current count against elapsed ticks. They also show whether a request lands on the right tick, and how re-arming behaves when the mask is cleared before or after zero is reached.

// File: rtl/lit_pkg.sv
package lit_pkg;
    localparam int ADDR_W     = 8;
    localparam int DIV_CODE_W = 3;
    localparam int MASK_BIT   = 16;
    localparam int PERIOD_BIT = 17;

    localparam logic [ADDR_W-1:0] IDX_CTRL  = 8'h32;
    localparam logic [ADDR_W-1:0] IDX_START = 8'h38;
    localparam logic [ADDR_W-1:0] IDX_COUNT = 8'h39;
    localparam logic [ADDR_W-1:0] IDX_DIV   = 8'h3E;

    localparam logic [31:0] CTRL_RESET = 32'h0001_0000;
endpackage

// File: rtl/lit_regs.sv
module lit_regs #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [lit_pkg::ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [CNT_W-1:0]              cur_count,
    output logic [DATA_W-1:0]             rdata,
    output logic [DATA_W-1:0]             ctrl_q,
    output logic [DATA_W-1:0]             ctrl_nxt,
    output logic [DATA_W-1:0]             start_q,
    output logic [lit_pkg::DIV_CODE_W-1:0] div_code,
    output logic                          load,
    output logic                          ctrl_wr
);
    import lit_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0]     ctrl;
        logic [DATA_W-1:0]     start;
        logic [DIV_CODE_W-1:0] div;
    } regs_t;

    regs_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (addr)
                IDX_CTRL:  st_d.ctrl  = wdata;
                IDX_START: st_d.start = wdata;
                IDX_DIV:   st_d.div   = {wdata[3], wdata[1], wdata[0]};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl  <= DATA_W'(CTRL_RESET);
            st_q.start <= '0;
            st_q.div   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            IDX_CTRL:  rdata = st_q.ctrl;
            IDX_START: rdata = st_q.start;
            IDX_COUNT: rdata = DATA_W'(cur_count);
            IDX_DIV:   rdata = DATA_W'({st_q.div[2], 1'b0, st_q.div[1:0]});
            default:   rdata = '0;
        endcase
    end

    assign ctrl_q   = st_q.ctrl;
    assign ctrl_nxt = st_d.ctrl;
    assign start_q  = st_q.start;
    assign div_code = st_q.div;
    assign load     = wr_en && (addr == IDX_START);
    assign ctrl_wr  = wr_en && (addr == IDX_CTRL);

    // R7: a write aimed at the current count leaves every register untouched
    p_count_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == IDX_COUNT) |=>
            ($stable(st_q.ctrl) && $stable(st_q.start) && $stable(st_q.div)));
endmodule

// File: rtl/lit_prescale.sv
module lit_prescale #(
    parameter int CODE_W = lit_pkg::DIV_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              restart,
    input  logic [CODE_W-1:0] div_code,
    output logic              div_tick
);
    localparam int PRE_W = (1 << CODE_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t pre_q, pre_d;
    logic [CODE_W-1:0] shift;
    logic [PRE_W-1:0]  last;

    assign shift = div_code + CODE_W'(1);
    assign last  = ~({PRE_W{1'b1}} << shift);

    always_comb begin
        pre_d    = pre_q;
        div_tick = 1'b0;
        if (restart) begin
            pre_d.cnt = '0;
        end else if (tick_en) begin
            if (pre_q.cnt >= last) begin
                pre_d.cnt = '0;
                div_tick  = 1'b1;
            end else begin
                pre_d.cnt = pre_q.cnt + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2: loading a start value restarts the divider from zero
    p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q.cnt == '0));
endmodule

// File: rtl/lit_core.sv
module lit_core #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_nxt,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] start_q,
    output logic [CNT_W-1:0]  cur_count,
    output logic              irq_pulse,
    output logic [VEC_W-1:0]  irq_vector
);
    import lit_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cur;
        logic             armed;
        logic             pulse;
        logic [VEC_W-1:0] vec;
    } core_t;

    core_t c_q, c_d;
    logic  periodic, masked;

    assign periodic = ctrl_q[PERIOD_BIT];
    assign masked   = ctrl_q[MASK_BIT];

    always_comb begin
        c_d       = c_q;
        c_d.pulse = 1'b0;
        if (div_tick) begin
            if (c_q.cur != '0) begin
                c_d.cur = c_q.cur - CNT_W'(1);
            end else begin
                if (periodic) c_d.cur = start_q[CNT_W-1:0];
                if (c_q.armed) begin
                    c_d.pulse = 1'b1;
                    c_d.vec   = ctrl_q[VEC_W-1:0];
                end
                if (!periodic) c_d.armed = 1'b0;
            end
        end
        if (ctrl_wr) begin
            c_d.armed = !ctrl_nxt[MASK_BIT] &&
                        (ctrl_nxt[PERIOD_BIT] || (c_d.cur != '0));
        end
        if (load) begin
            c_d.cur   = load_val[CNT_W-1:0];
            c_d.armed = !masked && (periodic || (load_val[CNT_W-1:0] != '0));
            c_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cur_count  = c_q.cur;
    assign irq_pulse  = c_q.pulse;
    assign irq_vector = c_q.vec;

    // R3: a request only follows a divided tick taken at count zero
    p_fire_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.pulse |-> $past(c_q.cur == '0 && div_tick));

    // R3: an expired one-shot count stays at zero
    p_oneshot_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && c_q.cur == '0 && !load) |=> (c_q.cur == '0));

    // R4: periodic mode reloads the start value after zero
    p_periodic_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (periodic && c_q.cur == '0 && div_tick && !load) |=>
            (c_q.cur == $past(start_q[CNT_W-1:0])));

    // R5: an expiry is never armed while the control word is masked
    p_armed_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.armed |-> !masked);

    // R6: the vector holds between requests
    p_vector_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.pulse |-> $stable(c_q.vec));
endmodule

// File: rtl/local_irq_timer.sv
module local_irq_timer #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_en,
    input  logic                       reg_wr,
    input  logic [lit_pkg::ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic                       irq_pulse,
    output logic [VEC_W-1:0]           irq_vector
);
    logic [DATA_W-1:0]              ctrl_q, ctrl_nxt, start_q;
    logic [lit_pkg::DIV_CODE_W-1:0] div_code;
    logic                           load, ctrl_wr, div_tick;
    logic [CNT_W-1:0]               cur_count;

    lit_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .cur_count(cur_count), .rdata(reg_rdata),
        .ctrl_q(ctrl_q), .ctrl_nxt(ctrl_nxt), .start_q(start_q),
        .div_code(div_code), .load(load), .ctrl_wr(ctrl_wr)
    );

    lit_prescale #(.CODE_W(lit_pkg::DIV_CODE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(load),
        .div_code(div_code), .div_tick(div_tick)
    );

    lit_core #(.DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .div_tick(div_tick), .load(load),
        .load_val(reg_wdata), .ctrl_wr(ctrl_wr), .ctrl_nxt(ctrl_nxt),
        .ctrl_q(ctrl_q), .start_q(start_q), .cur_count(cur_count),
        .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );
endmodule

// File: tb/local_irq_timer_test.sv
module local_irq_timer_test;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    local_irq_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        tick_en = 1'b0; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic cyc(input bit en);
        tick_en = en;
        @(posedge clk); #1;
        tick_en = 1'b0;
    endtask

    // Runs one configuration and checks every cycle against elapsed-tick arithmetic.
    task automatic run_cfg(input int code, input int start, input bit per,
                           input bit msk, input logic [7:0] vec, input int nticks);
        logic [31:0] rv;
        int shift, ratio, e, pc;
        bit ev, fire;
        logic [31:0] exp_cur;
        logic [31:0] divbits;
        divbits = ((code >> 2) & 1) << 3 | ((code >> 1) & 1) << 1 | (code & 1);
        wr(8'h3E, divbits | 32'hFFFF_FFF4);
        rd(8'h3E, rv);
        chk("R1 divider readback", rv, divbits);
        wr(8'h32, (32'(per) << 17) | (32'(msk) << 16) | 32'(vec));
        wr(8'h38, 32'(start));
        rd(8'h39, rv);
        chk("R2 load value", rv, 32'(start));
        shift = (code + 1) % 8;
        ratio = 1 << shift;
        e = 0; pc = 0;
        for (int t = 0; t < nticks * ratio * 2; t++) begin
            cyc(t % 2 == 0);
            ev = 0;
            if (t % 2 == 0) begin
                pc++;
                if (pc == ratio) begin pc = 0; e++; ev = 1; end
            end
            if (per) fire = ev && (e % (start + 1) == 0);
            else     fire = ev && (start > 0) && (e == start + 1);
            fire = fire && !msk;
            chk(per ? "R4 periodic request" : (msk ? "R5 masked request" : "R3 one-shot request"),
                32'(irq_pulse), 32'(fire));
            if (fire) chk("R6 vector", 32'(irq_vector), 32'(vec));
            if (per) exp_cur = 32'(start - (e % (start + 1)));
            else     exp_cur = (e >= start) ? 32'd0 : 32'(start - e);
            rd(8'h39, rv);
            chk(per ? "R4 periodic count" : "R3 one-shot count", rv, exp_cur);
        end
    endtask

    initial begin
        logic [31:0] rv;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R8 reset state
        rd(8'h32, rv); chk("R8 control reset", rv, 32'h0001_0000);
        rd(8'h38, rv); chk("R8 start reset", rv, 32'd0);
        rd(8'h3E, rv); chk("R8 divider reset", rv, 32'd0);
        rd(8'h39, rv); chk("R8 count reset", rv, 32'd0);
        chk("R8 pulse reset", 32'(irq_pulse), 32'd0);
        chk("R8 vector reset", 32'(irq_vector), 32'd0);

        // R1 R3 R4 R6 sweep over all divide codes
        for (int c = 0; c < 8; c++) begin
            run_cfg(c, 0, 1'b0, 1'b0, 8'(8'h20 + c), 3);
            run_cfg(c, 2, 1'b0, 1'b0, 8'(8'h40 + c), 7);
            run_cfg(c, 0, 1'b1, 1'b0, 8'(8'h60 + c), 3);
            run_cfg(c, 2, 1'b1, 1'b0, 8'(8'h80 + c), 7);
        end
        // R5 masked, count still advances
        run_cfg(7, 1, 1'b1, 1'b1, 8'hA5, 6);
        run_cfg(0, 3, 1'b0, 1'b1, 8'hA6, 6);

        // R6 vector holds after pulse; R7 count write ignored
        run_cfg(7, 1, 1'b0, 1'b0, 8'hC3, 3);
        cyc(1'b0);
        chk("R6 vector held", 32'(irq_vector), 32'hC3);
        chk("R6 single pulse", 32'(irq_pulse), 32'd0);
        wr(8'h38, 32'd9);
        wr(8'h39, 32'h55);
        rd(8'h39, rv); chk("R7 count write ignored", rv, 32'd9);
        rd(8'h38, rv); chk("R7 start unchanged", rv, 32'd9);
        rd(8'h32, rv); chk("R7 control unchanged", rv, 32'hC3);
        rd(8'h3E, rv); chk("R7 divider unchanged", rv, 32'hB);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, rv); chk("R7 unknown address reads zero", rv, 32'd0);
        rd(8'h38, rv); chk("R7 unknown write no effect", rv, 32'd9);

        // R2 restart mid-count: divide by 2 (code 0)
        wr(8'h3E, 32'h0);
        wr(8'h38, 32'd3);
        cyc(1'b1); cyc(1'b1); cyc(1'b1);
        rd(8'h39, rv); chk("R2 before restart", rv, 32'd2);
        wr(8'h38, 32'd6);
        cyc(1'b1);
        rd(8'h39, rv); chk("R2 restart divider half", rv, 32'd6);
        cyc(1'b1);
        rd(8'h39, rv); chk("R2 restart first step", rv, 32'd5);

        // R9 unmask while counting: fires at expiry
        wr(8'h3E, 32'hB);
        wr(8'h32, 32'h0001_0077);
        wr(8'h38, 32'd4);
        cyc(1'b1); cyc(1'b1);
        wr(8'h32, 32'h0000_0077);
        for (int k = 3; k <= 6; k++) begin
            cyc(1'b1);
            chk("R9 unmask before zero", 32'(irq_pulse), (k == 5) ? 32'd1 : 32'd0);
            if (k == 5) chk("R9 vector", 32'(irq_vector), 32'h77);
        end
        // R9 unmask after zero: no request
        wr(8'h32, 32'h0001_0088);
        wr(8'h38, 32'd2);
        cyc(1'b1); cyc(1'b1);
        rd(8'h39, rv); chk("R9 reached zero", rv, 32'd0);
        wr(8'h32, 32'h0000_0088);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1);
            chk("R9 unmask after zero", 32'(irq_pulse), 32'd0);
        end
        chk("R9 vector unchanged", 32'(irq_vector), 32'h77);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule